// File: doc/BRIEF.md
# PWM Channel with Buffered Period and Pulse-Width Update

This block is one pulse-width-modulated output channel with a small register port. A host writes a period, a pulse width and a control word. When the channel is running, an 8-bit prescaler divides the system clock. Each prescaler overflow advances a period counter. An output flip-flop is high while the counter is below the active pulse width. The flip-flop drives the pin directly or inverted. When the channel is stopped, the pin is a plain general-purpose I/O whose direction comes from a control bit.

New period and pulse-width values can be held in buffer registers until the counter wraps, so a period is never cut short or stretched by a write. In direct-write mode they take effect at once. A freeze input, honoured only when the control word allows it, halts the prescaler, the counter and the output where they are.

Top module: `pwm_chan`

## Requirements
- R1: After reset the period buffer, pulse-width buffer and control word are all zero, the pin is released (`pad_oe`=0), and a read of the control word returns 0 while `pad_i` is low.
- R2: Register map: address 0 is the period buffer, 1 is the pulse-width buffer, 2 is the control word, and 3 is the period counter (read only). `rdata` shows the addressed value one clock after `addr` is presented.
- R3: Control word layout: bit 15 run enable, bit 14 polarity, bit 13 direct-write mode, bit 12 freeze permission, bit 11 I/O direction (1 = output), bit 10 pin level, bits 9:8 read 0, bits 7:0 prescaler modulus. Bit 10 reads the level on `pad_i`, and writing it has no effect.
- R4: With run enable at 0, `pad_oe` equals the direction bit, and an output pin is driven with the polarity bit's level.
- R5: With run enable at 1, `pad_oe` is 1. With period P≥1 and pulse width W, the output is high for min(W,P) of every P counter steps. W=0 gives a constant low and W≥P gives a constant high.
- R6: With the polarity bit at 0 the running waveform is inverted on `pad_o`. With it at 1 the output flip-flop is driven directly.
- R7: The counter advances once every 256−CP clocks. CP is loaded into the prescaler on the clock after run enable rises, so the first step lands 256−CP+1 clocks after the enabling write edge.
- R8: With direct-write mode at 0, a pulse-width or period write during a period takes effect only when the counter wraps to 0.
- R9: With direct-write mode at 1, a pulse-width or period write goes into the active register at once. The new width decides the output from the next counter step onward.
- R10: With freeze permission at 1 and `freeze_i` high, the prescaler, the counter and the output level hold, and counting resumes from there on release. With freeze permission at 0, `freeze_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| freeze_i | input | 1 | External freeze request |
| pad_i | input | 1 | Level sensed on the pin |
| pad_o | output | 1 | Level driven onto the pin |
| pad_oe | output | 1 | Pin output enable |

## Verification
Control writes reach `pad_oe` and the idle-mode `pad_o` by the falling edge after the write edge. Read data appears at the falling edge after the clock that follows an address change, so every read waits one full clock. After an enabling write, the prescaler load takes one clock and each counter step takes 256−CP clocks. Duty is therefore measured over a whole number of periods that begin two clocks after the enable, and the first-step check samples at exactly 256−CP and 256−CP+1 clocks. The buffered and direct-write cases use the slowest prescaler and poll the counter through address 3. This leaves hundreds of clocks between a counter change and the sample, which absorbs the one-clock read lag.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W = 16;
    localparam int PS_W   = 8;

    typedef enum logic [1:0] {
        A_PERIOD = 2'd0,
        A_WIDTH  = 2'd1,
        A_CTRL   = 2'd2,
        A_COUNT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            en;
        logic            pol_hi;
        logic            direct;
        logic            frz_en;
        logic            dir_out;
        logic [PS_W-1:0] cp;
    } ctl_t;

    function automatic logic [DATA_W-1:0] ctl_pack(ctl_t c, logic pin);
        return {c.en, c.pol_hi, c.direct, c.frz_en, c.dir_out, pin, 2'b00, c.cp};
    endfunction

    function automatic ctl_t ctl_unpack(logic [DATA_W-1:0] w);
        ctl_t c;
        c.en      = w[15];
        c.pol_hi  = w[14];
        c.direct  = w[13];
        c.frz_en  = w[12];
        c.dir_out = w[11];
        c.cp      = w[PS_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            load,
    input  logic [PS_W-1:0] cp,
    output logic            tick,
    output logic [PS_W-1:0] pcnt
);
    logic at_top;

    assign at_top = (pcnt == {PS_W{1'b1}});
    assign tick   = run & at_top & ~load;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (load) begin
            pcnt <= cp;
        end else if (run) begin
            pcnt <= at_top ? cp : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_period.sv
module pwm_period
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             en_rise,
    input  logic             tick,
    input  logic             direct,
    input  logic             wr_per,
    input  logic             wr_pw,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] per_buf,
    input  logic [CNT_W-1:0] pw_buf,
    output logic [CNT_W-1:0] ctr,
    output logic             out_ff
);
    logic [CNT_W-1:0] per_act, pw_act, ctr_n, pw_n;
    logic [CNT_W:0]   inc;
    logic             wrap;

    always_comb begin
        inc   = {1'b0, ctr} + 1'b1;
        wrap  = (inc >= {1'b0, per_act});
        ctr_n = wrap ? '0 : inc[CNT_W-1:0];
        pw_n  = (wrap && !direct) ? pw_buf : pw_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr     <= '0;
            per_act <= '0;
            pw_act  <= '0;
            out_ff  <= 1'b0;
        end else if (!en) begin
            ctr     <= '0;
            per_act <= per_buf;
            pw_act  <= pw_buf;
            out_ff  <= 1'b0;
        end else begin
            if (en_rise) begin
                ctr    <= '0;
                out_ff <= (pw_act != '0);
            end else if (tick) begin
                ctr    <= ctr_n;
                out_ff <= (ctr_n < pw_n);
                if (wrap && !direct) begin
                    per_act <= per_buf;
                    pw_act  <= pw_buf;
                end
            end
            if (direct && wr_per) per_act <= wval;
            if (direct && wr_pw)  pw_act  <= wval;
        end
    end
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin (
    input  logic en,
    input  logic pol_hi,
    input  logic dir_out,
    input  logic out_ff,
    output logic pad_o,
    output logic pad_oe
);
    assign pad_oe = en | dir_out;
    assign pad_o  = en ? (pol_hi ? out_ff : ~out_ff) : pol_hi;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              freeze_i,
    input  logic              pad_i,
    output logic              pad_o,
    output logic              pad_oe
);
    ctl_t             ctl;
    logic [CNT_W-1:0] per_buf, pw_buf, ctr;
    logic [PS_W-1:0]  pcnt;
    logic             en_q, en_rise, frozen, run, tick, out_ff;
    logic             wr_per, wr_pw;
    reg_addr_e        a;

    assign a       = reg_addr_e'(addr);
    assign en_rise = ctl.en & ~en_q;
    assign frozen  = ctl.frz_en & freeze_i;
    assign run     = ctl.en & ~frozen;
    assign wr_per  = we && (a == A_PERIOD);
    assign wr_pw   = we && (a == A_WIDTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            per_buf <= '0;
            pw_buf  <= '0;
            en_q    <= 1'b0;
        end else begin
            en_q <= ctl.en;
            if (wr_per) per_buf <= wdata[CNT_W-1:0];
            if (wr_pw)  pw_buf  <= wdata[CNT_W-1:0];
            if (we && (a == A_CTRL)) ctl <= ctl_unpack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            unique case (a)
                A_PERIOD: rdata <= DATA_W'(per_buf);
                A_WIDTH:  rdata <= DATA_W'(pw_buf);
                A_CTRL:   rdata <= ctl_pack(ctl, pad_i);
                A_COUNT:  rdata <= DATA_W'(ctr);
            endcase
        end
    end

    pwm_prescale u_ps (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .load (en_rise),
        .cp   (ctl.cp),
        .tick (tick),
        .pcnt (pcnt)
    );

    pwm_period #(.CNT_W(CNT_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .en      (ctl.en),
        .en_rise (en_rise),
        .tick    (tick),
        .direct  (ctl.direct),
        .wr_per  (wr_per),
        .wr_pw   (wr_pw),
        .wval    (wdata[CNT_W-1:0]),
        .per_buf (per_buf),
        .pw_buf  (pw_buf),
        .ctr     (ctr),
        .out_ff  (out_ff)
    );

    pwm_pin u_pin (
        .en      (ctl.en),
        .pol_hi  (ctl.pol_hi),
        .dir_out (ctl.dir_out),
        .out_ff  (out_ff),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             en_q,
    input logic             dir_out,
    input logic             frz_en,
    input logic             freeze_i,
    input logic             pad_oe,
    input logic             out_ff,
    input logic [CNT_W-1:0] ctr,
    input logic [PS_W-1:0]  pcnt,
    input logic [PS_W-1:0]  cp
);
    AST_OE_WHEN_RUN: assert property (@(posedge clk) disable iff (rst)
        en |-> pad_oe); // R5

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!en && !dir_out) |-> !pad_oe); // R4

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frz_en && freeze_i && en && en_q) |=> ($stable(ctr) && $stable(out_ff))); // R10

    AST_PS_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en && !en_q) |=> (pcnt == $past(cp))); // R7

    AST_IDLE_COUNTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ctr == '0)); // R5
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W), .PS_W(pwm_pkg::PS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl.en),
    .en_q     (en_q),
    .dir_out  (ctl.dir_out),
    .frz_en   (ctl.frz_en),
    .freeze_i (freeze_i),
    .pad_oe   (pad_oe),
    .out_ff   (out_ff),
    .ctr      (ctr),
    .pcnt     (pcnt),
    .cp       (ctl.cp)
);

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        freeze_i = 1'b0;
    logic        ext_lvl = 1'b0;
    logic        pad_i, pad_o, pad_oe;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [15:0] EN  = 16'h8000;
    localparam logic [15:0] POL = 16'h4000;
    localparam logic [15:0] DIR = 16'h2000;
    localparam logic [15:0] FRZ = 16'h1000;
    localparam logic [15:0] OUT = 16'h0800;
    localparam logic [15:0] PIN = 16'h0400;

    always #5 clk = ~clk;
    assign pad_i = pad_oe ? pad_o : ext_lvl;

    pwm_chan u0 (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .freeze_i(freeze_i), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        v = rdata;
    endtask

    task automatic wait_cnt(input int v);
        @(negedge clk);
        addr = 2'd3;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rdata == 16'(v)) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int highs, exp_h, r, cpv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(pad_oe == 1'b0, "R1 oe", pad_oe, 0);
        rd(2'd2, v); chk(v == 16'h0000, "R1 ctrl", v, 0);
        rd(2'd0, v); chk(v == 16'h0000, "R1 period", v, 0);
        rd(2'd1, v); chk(v == 16'h0000, "R1 width", v, 0);

        // R2 readback
        wr(2'd0, 16'h1234); rd(2'd0, v); chk(v == 16'h1234, "R2 period", v, 16'h1234);
        wr(2'd1, 16'hBEEF); rd(2'd1, v); chk(v == 16'hBEEF, "R2 width", v, 16'hBEEF);
        rd(2'd3, v); chk(v == 16'h0000, "R2 counter idle", v, 0);

        // R3 pin bit read only, layout
        wr(2'd2, PIN | 16'h035A); rd(2'd2, v); chk(v == 16'h005A, "R3 pin ignored", v, 16'h005A);
        ext_lvl = 1'b1; rd(2'd2, v); chk(v == 16'h045A, "R3 pin level", v, 16'h045A);
        ext_lvl = 1'b0;

        // R4 idle I/O
        wr(2'd2, OUT | POL); chk(pad_oe && pad_o, "R4 out high", {pad_oe, pad_o}, 3);
        wr(2'd2, OUT);       chk(pad_oe && !pad_o, "R4 out low", {pad_oe, pad_o}, 2);
        wr(2'd2, 16'h0000);  chk(!pad_oe, "R4 input", pad_oe, 0);

        // R5/R7 duty sweep
        for (int p = 1; p <= 5; p++) begin
            for (int w = 0; w <= 6; w++) begin
                for (int k = 0; k < 3; k++) begin
                    cpv = 255 - k; r = 256 - cpv;
                    wr(2'd2, 16'h0000);
                    wr(2'd0, 16'(p));
                    wr(2'd1, 16'(w));
                    wr(2'd2, EN | POL | 16'(cpv));
                    repeat (2) @(negedge clk);
                    highs = 0;
                    for (int c = 0; c < 2 * p * r; c++) begin
                        @(negedge clk);
                        if (pad_o) highs++;
                    end
                    exp_h = 2 * ((w < p) ? w : p) * r;
                    chk(highs == exp_h && pad_oe, "R5 R7 duty", highs, exp_h);
                end
            end
        end

        // R6 inverted polarity, width 0 -> constant high on pin
        wr(2'd2, 16'h0000); wr(2'd0, 16'd3); wr(2'd1, 16'd0);
        wr(2'd2, EN | 16'h00FF);
        highs = 0;
        for (int c = 0; c < 12; c++) begin @(negedge clk); if (pad_o) highs++; end
        chk(highs == 12, "R6 inverted", highs, 12);

        // R7 first step after enable, CP = 0xC0
        wr(2'd2, 16'h0000); wr(2'd0, 16'd8); wr(2'd1, 16'd1);
        wr(2'd2, EN | POL | 16'h00C0);
        repeat (64) @(posedge clk);
        @(negedge clk); chk(pad_o == 1'b1, "R7 before step", pad_o, 1);
        @(posedge clk); @(negedge clk); chk(pad_o == 1'b0, "R7 at step", pad_o, 0);

        // R8 buffered update at wrap
        wr(2'd2, 16'h0000); wr(2'd0, 16'd4); wr(2'd1, 16'd1);
        wr(2'd2, EN | POL | 16'h0000);
        wait_cnt(1); wr(2'd1, 16'd3);
        wait_cnt(2); repeat (5) @(negedge clk);
        chk(pad_o == 1'b0, "R8 held", pad_o, 0);
        wait_cnt(0); wait_cnt(2); repeat (5) @(negedge clk);
        chk(pad_o == 1'b1, "R8 applied", pad_o, 1);

        // R9 direct write
        wr(2'd2, 16'h0000); wr(2'd0, 16'd4); wr(2'd1, 16'd1);
        wr(2'd2, EN | POL | DIR | 16'h0000);
        wait_cnt(1); wr(2'd1, 16'd3);
        wait_cnt(2); repeat (5) @(negedge clk);
        chk(pad_o == 1'b1, "R9 immediate", pad_o, 1);

        // R10 freeze
        wr(2'd2, 16'h0000); wr(2'd0, 16'd4); wr(2'd1, 16'd2);
        wr(2'd2, EN | POL | FRZ | 16'h0000);
        wait_cnt(1);
        freeze_i = 1'b1;
        rd(2'd3, v); v2 = {15'd0, pad_o};
        repeat (600) @(negedge clk);
        rd(2'd3, highs[15:0]);
        chk(highs[15:0] == v, "R10 frozen count", highs[15:0], v);
        chk(pad_o == v2[0], "R10 frozen level", pad_o, v2[0]);
        freeze_i = 1'b0;
        repeat (600) @(negedge clk);
        rd(2'd3, v2);
        chk(v2 != v, "R10 resumes", v2, v + 2);
        wr(2'd2, EN | POL | 16'h0000);
        freeze_i = 1'b1;
        rd(2'd3, v);
        repeat (600) @(negedge clk);
        rd(2'd3, v2);
        chk(v2 != v, "R10 freeze ignored", v2, v + 2);
        freeze_i = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule